// File: doc/BRIEF.md
# Receive Frame Buffer Formatter

This block sits between the receive side of an Ethernet MAC and the packet memory. For each incoming frame it is told the frame length up front, asks the page allocator for one 2 KB packet page, and writes the frame into that page one byte per cycle in a fixed layout. The layout is a status halfword, a byte-count halfword, the payload, an optional CRC, and a two-byte tail. When the last byte is written it hands the page number to the receive queue and raises a one-cycle receive event.

Frames are not stored in three cases: reception is switched off, the soft-reset control is set, or the laid-out frame would not fit in a page. A frame is also not stored when the allocator refuses a page. A refused frame is still drained from the byte stream, so the source never stalls. Frames shorter than the minimum are zero-padded. A frame whose padded length is odd gets special treatment: its last byte goes after the CRC, followed by an odd-frame marker. The CRC value comes from a separate CRC-32 unit, which holds its result on `crc_value` until the frame completes.

Top module: `rx_frame_fmt`

## Requirements
- R1: After reset the block is idle. `fr_ready` is 1, and `wr_en`, `pg_req`, `rxq_push` and `rx_event` are 0.
- R2: A frame that starts while `ctl_rx_en` is 0 or `ctl_soft_rst` is 1 is dropped. No page is requested, nothing is written and nothing is pushed. All of its bytes are still accepted, and `fr_ready` returns afterwards.
- R3: If the allocator answers `pg_fail` with no `pg_grant`, the frame is dropped. Nothing is written, nothing is pushed, and its bytes are drained.
- R4: The status halfword goes to bytes 0 (low) and 1 (high). Only bit 12 may be set, and it is set exactly when the padded length is odd. The byte count goes to bytes 2 (low) and 3 (high).
- R5: The byte count is 6 plus the padded length rounded down to even, plus 4 when the CRC is kept. Exactly that many bytes are written.
- R6: Payload bytes start at byte 4 in arrival order. A frame of fewer than 64 bytes is followed by zero bytes up to 64 payload bytes.
- R7: A frame whose byte count would exceed 2048 is not stored, requests no page, and is drained.
- R8: With `ctl_strip_crc` = 0 at frame start, the 4 CRC bytes follow the even payload, least significant byte first. With `ctl_strip_crc` = 1 they are omitted.
- R9: For an odd padded length, the last frame byte is written after the CRC position, then 0x20. For an even length the last two bytes are 0x00, 0x00.
- R10: After the final write, `rxq_push` and `rx_event` are high together for exactly one cycle, with `rxq_page` equal to the granted page. `fr_ready` follows in the next cycle.
- R11: All writes of a frame go to the granted page. Each write address is one above the previous one, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_rx_en | input | 1 | Reception enabled |
| ctl_soft_rst | input | 1 | Soft reset active; frames are refused |
| ctl_strip_crc | input | 1 | Leave the CRC out of the stored frame |
| fr_start | input | 1 | Frame start, taken when `fr_ready` is 1 |
| fr_len | input | 16 | Frame length in bytes (at least 1) |
| fr_ready | output | 1 | Idle, able to take a frame start |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte accepted when both valid and ready |
| crc_value | input | 32 | Frame CRC from the CRC-32 unit |
| pg_req | output | 1 | Page request |
| pg_grant | input | 1 | Page granted |
| pg_fail | input | 1 | No page free |
| pg_num | input | PG_W | Granted page number |
| wr_en | output | 1 | RAM byte write strobe |
| wr_page | output | PG_W | Page being written |
| wr_addr | output | 11 | Byte offset in the page |
| wr_data | output | 8 | Byte to write |
| rxq_push | output | 1 | Push page number to the receive queue |
| rxq_page | output | PG_W | Page number pushed |
| rx_event | output | 1 | Receive event pulse |

## Verification
The bench drives inputs at the falling edge. An accepted byte is therefore written at the following rising edge. Header bytes start the cycle after the grant cycle, and payload writes track the byte stream one for one. Pad, CRC and tail bytes follow at one per cycle, with one idle cycle at the end of padding.

The completion pulse comes one cycle after the last tail write. The bench polls for it at falling edges within a bounded window and only then compares the page image with its own model. For dropped frames, the bench counts accepted bytes until the whole frame is drained. It then checks the write, request and push counts a few cycles later.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

    localparam int PAGE_BYTES     = 2048;
    localparam int AW             = $clog2(PAGE_BYTES);
    localparam int LEN_W          = 16;
    localparam int MIN_PAYLOAD    = 64;
    localparam int HDR_BYTES      = 4;
    localparam int CRC_BYTES      = 4;
    localparam int TAIL_BYTES     = 2;
    localparam int ODD_STATUS_BIT = 12;
    localparam logic [7:0] ODD_MARK = 8'h20;
    localparam int PAD_END        = HDR_BYTES + MIN_PAYLOAD;

    typedef enum logic [3:0] {
        S_IDLE, S_ALLOC, S_HDR, S_DATA, S_PAD, S_CRC, S_TAIL, S_DONE, S_DRAIN
    } phase_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             odd;
        logic             add_crc;
        logic [15:0]      count;
        logic [15:0]      status;
        logic             fits;
    } plan_t;

    function automatic plan_t build_plan(input logic [LEN_W-1:0] len, input logic strip);
        plan_t p;
        logic [LEN_W:0] padded;
        logic [LEN_W:0] even;
        logic [LEN_W:0] cnt;
        padded = (len < LEN_W'(MIN_PAYLOAD)) ? (LEN_W+1)'(MIN_PAYLOAD) : {1'b0, len};
        even   = {padded[LEN_W:1], 1'b0};
        cnt    = even + (LEN_W+1)'(HDR_BYTES + TAIL_BYTES)
               + (strip ? '0 : (LEN_W+1)'(CRC_BYTES));
        p.len     = len;
        p.odd     = padded[0];
        p.add_crc = !strip;
        p.count   = cnt[15:0];
        p.status  = 16'(padded[0]) << ODD_STATUS_BIT;
        p.fits    = (cnt <= (LEN_W+1)'(PAGE_BYTES));
        return p;
    endfunction

endpackage

// File: rtl/rxfmt_plan.sv
module rxfmt_plan
    import rxfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output plan_t            plan_now,
    output plan_t            plan_q
);
    assign plan_now = build_plan(len, strip);

    always_ff @(posedge clk) begin
        if (rst)       plan_q <= '0;
        else if (load) plan_q <= plan_now;
    end
endmodule

// File: rtl/rxfmt_bytesel.sv
module rxfmt_bytesel
    import rxfmt_pkg::*;
(
    input  phase_t      phase,
    input  logic [1:0]  sub,
    input  plan_t       plan,
    input  logic [7:0]  in_data,
    input  logic [31:0] crc_value,
    input  logic [7:0]  last_byte,
    output logic [7:0]  wr_byte
);
    always_comb begin
        wr_byte = 8'h00;
        case (phase)
            S_HDR: begin
                case (sub)
                    2'd0:    wr_byte = plan.status[7:0];
                    2'd1:    wr_byte = plan.status[15:8];
                    2'd2:    wr_byte = plan.count[7:0];
                    default: wr_byte = plan.count[15:8];
                endcase
            end
            S_DATA:  wr_byte = in_data;
            S_CRC:   wr_byte = crc_value[8*sub +: 8];
            S_TAIL: begin
                if (sub == 2'd0) wr_byte = plan.odd ? last_byte : 8'h00;
                else             wr_byte = plan.odd ? ODD_MARK  : 8'h00;
            end
            default: wr_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/rxfmt_seq.sv
module rxfmt_seq
    import rxfmt_pkg::*;
#(
    parameter int PG_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fr_start,
    input  logic            store_ok,
    input  plan_t           plan_q,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            pg_grant,
    input  logic            pg_fail,
    input  logic [PG_W-1:0] pg_num,
    output logic            fr_ready,
    output logic            in_ready,
    output logic            pg_req,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [PG_W-1:0] page_q,
    output phase_t          phase,
    output logic [1:0]      sub,
    output logic [7:0]      last_byte,
    output logic            done
);
    phase_t           state;
    logic [AW:0]      addr_q;
    logic [LEN_W-1:0] pcnt;
    logic [LEN_W-1:0] last_idx;
    logic             capture;

    assign last_idx = plan_q.len - LEN_W'(1);
    assign wr_addr  = addr_q[AW-1:0];
    assign phase    = state;

    always_comb begin
        fr_ready = 1'b0;
        in_ready = 1'b0;
        pg_req   = 1'b0;
        wr_en    = 1'b0;
        done     = 1'b0;
        capture  = 1'b0;
        case (state)
            S_IDLE:                fr_ready = 1'b1;
            S_ALLOC:               pg_req   = 1'b1;
            S_HDR, S_CRC, S_TAIL:  wr_en    = 1'b1;
            S_DATA: begin
                in_ready = 1'b1;
                capture  = plan_q.odd && (pcnt == last_idx);
                wr_en    = in_valid && !capture;
            end
            S_PAD:   wr_en    = (addr_q < (AW+1)'(PAD_END));
            S_DRAIN: in_ready = 1'b1;
            S_DONE:  done     = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            addr_q    <= '0;
            pcnt      <= '0;
            sub       <= '0;
            page_q    <= '0;
            last_byte <= '0;
        end else begin
            case (state)
                S_IDLE: if (fr_start) begin
                    pcnt  <= '0;
                    state <= store_ok ? S_ALLOC : S_DRAIN;
                end
                S_ALLOC: begin
                    if (pg_grant) begin
                        page_q <= pg_num;
                        addr_q <= '0;
                        sub    <= '0;
                        state  <= S_HDR;
                    end else if (pg_fail) begin
                        state <= S_DRAIN;
                    end
                end
                S_HDR: begin
                    addr_q <= addr_q + 1'b1;
                    sub    <= sub + 1'b1;
                    if (sub == 2'd3) state <= S_DATA;
                end
                S_DATA: if (in_valid) begin
                    pcnt <= pcnt + 1'b1;
                    if (capture) last_byte <= in_data;
                    if (wr_en)   addr_q <= addr_q + 1'b1;
                    if (pcnt == last_idx) state <= S_PAD;
                end
                S_PAD: begin
                    if (wr_en) addr_q <= addr_q + 1'b1;
                    else begin
                        sub   <= '0;
                        state <= plan_q.add_crc ? S_CRC : S_TAIL;
                    end
                end
                S_CRC: begin
                    addr_q <= addr_q + 1'b1;
                    sub    <= sub + 1'b1;
                    if (sub == 2'd3) state <= S_TAIL;
                end
                S_TAIL: begin
                    addr_q <= addr_q + 1'b1;
                    sub    <= sub + 1'b1;
                    if (sub == 2'd1) state <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
                S_DRAIN: if (in_valid) begin
                    pcnt <= pcnt + 1'b1;
                    if (pcnt == last_idx) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse
    a_r10_push_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: consecutive writes of a frame step the address by one
    a_r11_addr_step: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> addr_q == $past(addr_q) + 1'b1);

    // R7: only frames that fit reach the header phase
    a_r7_stored_fits: assert property (@(posedge clk) disable iff (rst)
        (state == S_HDR) |-> plan_q.fits);

    // R5: bytes written equal the planned count at completion
    a_r5_count_at_push: assert property (@(posedge clk) disable iff (rst)
        done |-> ({{(15-AW){1'b0}}, addr_q} == plan_q.count));

    // R3: a refused page drains the frame
    a_r3_fail_drains: assert property (@(posedge clk) disable iff (rst)
        (state == S_ALLOC && pg_fail && !pg_grant) |=> (state == S_DRAIN));

    // R6: padding completes before CRC and tail
    a_r6_min_payload: assert property (@(posedge clk) disable iff (rst)
        (state == S_CRC || state == S_TAIL) |-> addr_q >= (AW+1)'(PAD_END));
endmodule

// File: rtl/rx_frame_fmt.sv
module rx_frame_fmt
    import rxfmt_pkg::*;
#(
    parameter int PG_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_rx_en,
    input  logic            ctl_soft_rst,
    input  logic            ctl_strip_crc,
    input  logic            fr_start,
    input  logic [15:0]     fr_len,
    output logic            fr_ready,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    input  logic [31:0]     crc_value,
    output logic            pg_req,
    input  logic            pg_grant,
    input  logic            pg_fail,
    input  logic [PG_W-1:0] pg_num,
    output logic            wr_en,
    output logic [PG_W-1:0] wr_page,
    output logic [10:0]     wr_addr,
    output logic [7:0]      wr_data,
    output logic            rxq_push,
    output logic [PG_W-1:0] rxq_page,
    output logic            rx_event
);
    plan_t      plan_now;
    plan_t      plan_q;
    phase_t     phase;
    logic [1:0] sub;
    logic [7:0] last_byte;
    logic       done;
    logic       store_ok;
    logic [PG_W-1:0] page_q;

    assign store_ok = ctl_rx_en && !ctl_soft_rst && plan_now.fits;

    rxfmt_plan u_plan (
        .clk      (clk),
        .rst      (rst),
        .load     (fr_start && fr_ready),
        .len      (fr_len),
        .strip    (ctl_strip_crc),
        .plan_now (plan_now),
        .plan_q   (plan_q)
    );

    rxfmt_seq #(.PG_W(PG_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fr_start  (fr_start),
        .store_ok  (store_ok),
        .plan_q    (plan_q),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .pg_grant  (pg_grant),
        .pg_fail   (pg_fail),
        .pg_num    (pg_num),
        .fr_ready  (fr_ready),
        .in_ready  (in_ready),
        .pg_req    (pg_req),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .page_q    (page_q),
        .phase     (phase),
        .sub       (sub),
        .last_byte (last_byte),
        .done      (done)
    );

    rxfmt_bytesel u_sel (
        .phase     (phase),
        .sub       (sub),
        .plan      (plan_q),
        .in_data   (in_data),
        .crc_value (crc_value),
        .last_byte (last_byte),
        .wr_byte   (wr_data)
    );

    assign wr_page  = page_q;
    assign rxq_push = done;
    assign rxq_page = page_q;
    assign rx_event = done;

    // R1: idle block neither writes nor requests
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        fr_ready |-> (!wr_en && !pg_req && !rxq_push));

    // R10: idle follows completion
    a_r10_ready_after_push: assert property (@(posedge clk) disable iff (rst)
        rxq_push |=> fr_ready);
endmodule

// File: tb/tb_rx_frame_fmt.sv
module tb_rx_frame_fmt;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_rx_en, ctl_soft_rst, ctl_strip_crc;
    logic        fr_start;
    logic [15:0] fr_len;
    logic        fr_ready;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic [31:0] crc_value;
    logic        pg_req, pg_grant, pg_fail;
    logic [3:0]  pg_num;
    logic        wr_en;
    logic [3:0]  wr_page;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    logic        rxq_push;
    logic [3:0]  rxq_page;
    logic        rx_event;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rx_frame_fmt #(.PG_W(4)) dut (.*);

    logic [7:0] mem [0:2047];
    int wr_cnt = 0, req_cnt = 0, push_cnt = 0, bad_page = 0;
    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
            if (wr_page != pg_num) bad_page <= bad_page + 1;
        end
        if (pg_req)   req_cnt  <= req_cnt + 1;
        if (rxq_push) push_cnt <= push_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int len);
        return 8'((i * 13 + len) & 255);
    endfunction

    function automatic logic [7:0] exp_byte(input int a, input int len, input bit strip, input logic [31:0] crc);
        int padded, odd, ev, cnt, p;
        padded = (len < 64) ? 64 : len;
        odd = padded % 2;
        ev  = padded - odd;
        cnt = ev + 6 + (strip ? 0 : 4);
        if (a == 0) return 8'h00;
        if (a == 1) return odd ? 8'h10 : 8'h00;
        if (a == 2) return 8'(cnt & 255);
        if (a == 3) return 8'(cnt >> 8);
        if (a < 4 + ev) return (a - 4 < len) ? pat(a - 4, len) : 8'h00;
        p = 4 + ev;
        if (!strip) begin
            if (a < p + 4) return crc[8*(a-p) +: 8];
            p += 4;
        end
        if (a == p) return odd ? pat(len - 1, len) : 8'h00;
        return odd ? 8'h20 : 8'h00;
    endfunction

    task automatic send_frame(input int len);
        int i = 0;
        @(negedge clk);
        fr_start = 1'b1;
        fr_len = 16'(len);
        crc_value = {16'(len), ~16'(len)};
        @(negedge clk);
        fr_start = 1'b0;
        while (i < len) begin
            in_valid = 1'b1;
            in_data = pat(i, len);
            if (in_ready) i++;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic stored_frame(input int len, input bit strip, input logic [3:0] pg);
        int w0, p0, cnt, bad, first_bad, act_at, guard;
        bit seen, evt_ok;
        w0 = wr_cnt; p0 = push_cnt;
        ctl_strip_crc = strip;
        pg_num = pg;
        send_frame(len);
        seen = 0; evt_ok = 0; guard = 0;
        while (!seen && guard < 400) begin
            if (rxq_push) begin
                seen = 1;
                evt_ok = rx_event && (rxq_page == pg);
            end
            @(negedge clk);
            guard++;
        end
        cnt = ((len < 64 ? 64 : len) & ~1) + 6 + (strip ? 0 : 4);
        check(seen && evt_ok, "R10 completion push/event/page", int'(evt_ok), 1);
        check(fr_ready, "R10 ready after completion", int'(fr_ready), 1);
        check(push_cnt - p0 == 1, "R10 single push", push_cnt - p0, 1);
        check(wr_cnt - w0 == cnt, "R5 bytes written", wr_cnt - w0, cnt);
        bad = 0; first_bad = -1; act_at = 0;
        for (int a = 0; a < cnt; a++) begin
            if (mem[a] !== exp_byte(a, len, strip, crc_value)) begin
                if (first_bad < 0) begin first_bad = a; act_at = int'(mem[a]); end
                bad++;
            end
        end
        check(bad == 0, "R4 R6 R8 R9 page image", act_at,
              first_bad < 0 ? 0 : int'(exp_byte(first_bad, len, strip, crc_value)));
        if (bad != 0) $display("  first mismatch at offset %0d (len %0d)", first_bad, len);
        check(bad_page == 0, "R11 writes on granted page", bad_page, 0);
    endtask

    task automatic dropped_frame(input int len, input string req, input bit expect_req);
        int w0, p0, r0;
        w0 = wr_cnt; p0 = push_cnt; r0 = req_cnt;
        send_frame(len);
        repeat (3) @(negedge clk);
        check(wr_cnt == w0, {req, " no writes"}, wr_cnt - w0, 0);
        check(push_cnt == p0, {req, " no push"}, push_cnt - p0, 0);
        check((req_cnt != r0) == expect_req, {req, " page request"}, req_cnt - r0, int'(expect_req));
        check(fr_ready, {req, " drained, ready again"}, int'(fr_ready), 1);
    endtask

    // len, strip
    localparam logic [16:0] VEC [10] = '{
        {16'd1,    1'b0}, {16'd63,   1'b0}, {16'd64,   1'b1}, {16'd64,  1'b0},
        {16'd65,   1'b0}, {16'd65,   1'b1}, {16'd100,  1'b0}, {16'd127, 1'b1},
        {16'd2039, 1'b0}, {16'd2040, 1'b1}
    };

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ctl_rx_en = 1'b1; ctl_soft_rst = 1'b0; ctl_strip_crc = 1'b0;
        fr_start = 1'b0; fr_len = '0; in_valid = 1'b0; in_data = '0; crc_value = '0;
        pg_grant = 1'b1; pg_fail = 1'b0; pg_num = 4'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(fr_ready && !wr_en && !pg_req && !rxq_push && !rx_event,
              "R1 reset idle", int'(fr_ready), 1);

        // Table walk: R4 R5 R6 R8 R9 R10 R11
        foreach (VEC[k])
            stored_frame(int'(VEC[k][16:1]), VEC[k][0], 4'(k + 1));

        // R7: 2040 bytes with CRC kept needs 2050 bytes
        ctl_strip_crc = 1'b0;
        dropped_frame(2040, "R7 oversize", 1'b0);

        // R2: reception disabled, then soft reset
        ctl_rx_en = 1'b0;
        dropped_frame(80, "R2 rx disabled", 1'b0);
        ctl_rx_en = 1'b1; ctl_soft_rst = 1'b1;
        dropped_frame(81, "R2 soft reset", 1'b0);
        ctl_soft_rst = 1'b0;

        // R3: allocator refuses
        pg_grant = 1'b0; pg_fail = 1'b1;
        dropped_frame(70, "R3 alloc fail", 1'b1);
        pg_grant = 1'b1; pg_fail = 1'b0;

        // Recovery after drops
        stored_frame(67, 1'b0, 4'd9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule